// File: doc/BRIEF.md
# Multi-State Trigger Sequencer

This block decides when an acquisition unit stops collecting samples. It watches a stream of sampled data words and walks through a small programmable state machine. In each state a pair of clauses is tested against every accepted sample. A clause's condition can be one of several kinds:

- a masked equality, where only the selected bits are compared;
- an inclusive unsigned range test;
- the level of a line from a peer acquisition unit;
- whether an internal counter has reached its terminal value.

The first matching clause, in priority order, runs its action. The action may move to another state, advance or clear one of two counters, set an arm line toward a peer unit, or fire the trigger.

Configuration comes in through a plain write port. Every clause has two words, and each counter has one terminal-count word. Writes to the configuration never alter the sequencer position, the counters or the outputs. A re-arm pulse restarts the sequence from state 0 and keeps the configuration.

The sample input is a valid/ready stream. `smp_ready` is high from the first clock after reset until the trigger fires. It drops while the trigger is held and during any cycle with `rearm` high. A sample counts as taken only on a cycle where both `smp_valid` and `smp_ready` are high. While ready is low, the producer must hold off or drop its samples. The block never stores a sample it has not taken.

Top module: `tsq_trigger_seq`

## Requirements
- R1: After reset, and on the clock edge following a `rearm` pulse, `cur_state` is 0, `trig_out` and `arm_out` are low and both counters hold 0; clause configuration is kept across a re-arm.
- R2: Condition kind 1 (masked) matches when `(smp_data ^ A) & B` is zero. Word 1 of the clause holds A in bits [15:0] and B in bits [31:16]; a B bit of 1 means the data bit is compared.
- R3: Condition kind 2 (range) matches when A <= `smp_data` <= B, with the comparison unsigned and both bounds inclusive.
- R4: Condition kind 3 matches when `peer_in` is high on the cycle the sample is taken; kind 0 never matches and kind 5 always matches.
- R5: Condition kind 4 matches when the counter chosen by ctrl bit 3 equals its terminal value. The terminal value is written at address 16 (counter 0) or 17 (counter 1), data bits [15:0]. The comparison uses the counter value from before the current sample's action.
- R6: When both clauses of the current state match, only clause 0's action runs.
- R7: Conditions are evaluated only on cycles where a sample is taken; with no sample taken, state and outputs do not change.
- R8: A clause with ctrl bit 4 set moves the sequencer to the state in ctrl bits [6:5], visible on `cur_state` after the sampling edge; the next sample is tested against the new state's clauses.
- R9: Ctrl bit 10 sets `arm_out`, which then stays high until reset or re-arm.
- R10: Ctrl bit 11 sets `trig_out`, which stays high until reset or re-arm. While it is high, `smp_ready` is low and the state stays frozen.
- R11: Ctrl bit 7 increments and bit 8 clears the counter chosen by ctrl bit 9; when both are set, clear wins.
- R12: Clause registers sit at address `{state[1:0], clause, word}` in bits [3:0] with bit 4 low; word 0 is the ctrl word with the kind in bits [2:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rearm | input | 1 | Restart the sequence from state 0 |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| smp_valid | input | 1 | Sample word present |
| smp_ready | output | 1 | Sequencer can take a sample |
| smp_data | input | 16 | Sampled data word |
| peer_in | input | 1 | Arm/trigger line from a peer unit, sampled with the data |
| arm_out | output | 1 | Arm line toward a peer unit |
| trig_out | output | 1 | Acquisition trigger |
| cur_state | output | 2 | Current sequencer state |

## Verification
A corrupted state register appears on `cur_state` at the very next edge. It also changes which clauses test the next sample, so a wrong goto shows up one sample later as a missed or wrong transition. A counter that is wrong by even one count stays hidden until a terminal-count clause is tested. It then fires one sample early or late, so counter tests count samples up to the terminal value and check both sides of it. A sticky output that drops, or a frozen state that moves, shows on the ports one cycle after the offending edge.

// File: rtl/tsq_pkg.sv
package tsq_pkg;
  localparam int NUM_STATES  = 4;
  localparam int NUM_CLAUSES = 2;
  localparam int NUM_CNT     = 2;
  localparam int STATE_W     = $clog2(NUM_STATES);
  localparam int CL_W        = $clog2(NUM_CLAUSES);
  localparam int CSEL_W      = $clog2(NUM_CNT);
  localparam int NUM_ENTRIES = NUM_STATES * NUM_CLAUSES;

  typedef enum logic [2:0] {
    COND_NEVER  = 3'd0,
    COND_MASKED = 3'd1,
    COND_RANGE  = 3'd2,
    COND_PEER   = 3'd3,
    COND_COUNT  = 3'd4,
    COND_ALWAYS = 3'd5
  } cond_e;

  typedef struct packed {
    logic               fire;
    logic               arm;
    logic [CSEL_W-1:0]  act_cnt;
    logic               clr;
    logic               inc;
    logic [STATE_W-1:0] nxt;
    logic               go;
    logic [CSEL_W-1:0]  cond_cnt;
    logic [2:0]         kind;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/tsq_cfg_regs.sv
module tsq_cfg_regs
  import tsq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [2*DATA_W-1:0]   wdata,
  input  logic [STATE_W-1:0]    state,
  output ctrl_t                 ctrl_o [NUM_CLAUSES],
  output logic [DATA_W-1:0]     lo_o   [NUM_CLAUSES],
  output logic [DATA_W-1:0]     hi_o   [NUM_CLAUSES],
  output logic [CNT_W-1:0]      term_o [NUM_CNT]
);
  localparam int IDX_W = STATE_W + CL_W;

  ctrl_t             ctrl_mem [NUM_ENTRIES];
  logic [DATA_W-1:0] lo_mem   [NUM_ENTRIES];
  logic [DATA_W-1:0] hi_mem   [NUM_ENTRIES];
  logic [CNT_W-1:0]  term_mem [NUM_CNT];

  logic             term_sel;
  logic [IDX_W-1:0] wr_idx;
  assign term_sel = addr[ADDR_W-1];
  assign wr_idx   = addr[IDX_W:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        ctrl_mem[i] <= '0;
        lo_mem[i]   <= '0;
        hi_mem[i]   <= '0;
      end
      for (int k = 0; k < NUM_CNT; k++) term_mem[k] <= '0;
    end else if (we) begin
      if (term_sel) begin
        term_mem[addr[CSEL_W-1:0]] <= wdata[CNT_W-1:0];
      end else if (addr[0] == 1'b0) begin
        ctrl_mem[wr_idx] <= ctrl_t'(wdata[CTRL_W-1:0]);
      end else begin
        lo_mem[wr_idx] <= wdata[DATA_W-1:0];
        hi_mem[wr_idx] <= wdata[2*DATA_W-1:DATA_W];
      end
    end
  end

  for (genvar c = 0; c < NUM_CLAUSES; c++) begin : g_rd
    localparam logic [CL_W-1:0] CIDX = CL_W'(c);
    assign ctrl_o[c] = ctrl_mem[{state, CIDX}];
    assign lo_o[c]   = lo_mem[{state, CIDX}];
    assign hi_o[c]   = hi_mem[{state, CIDX}];
  end

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_term
    assign term_o[k] = term_mem[k];
  end
endmodule

// File: rtl/tsq_clause_eval.sv
module tsq_clause_eval
  import tsq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  ctrl_t              ctrl,
  input  logic [DATA_W-1:0]  lo,
  input  logic [DATA_W-1:0]  hi,
  input  logic [DATA_W-1:0]  data,
  input  logic               peer,
  input  logic [NUM_CNT-1:0] cnt_hit,
  output logic               hit
);
  always_comb begin
    case (cond_e'(ctrl.kind))
      COND_MASKED: hit = ((data ^ lo) & hi) == '0;
      COND_RANGE:  hit = (data >= lo) && (data <= hi);
      COND_PEER:   hit = peer;
      COND_COUNT:  hit = cnt_hit[ctrl.cond_cnt];
      COND_ALWAYS: hit = 1'b1;
      default:     hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/tsq_counter.sv
module tsq_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic [CNT_W-1:0] term,
  output logic             at_term
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (inc) cnt_q <= cnt_q + 1'b1;
  end

  assign at_term = (cnt_q == term);
endmodule

// File: rtl/tsq_trigger_seq.sv
module tsq_trigger_seq
  import tsq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rearm,
  input  logic                cfg_we,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [2*DATA_W-1:0] cfg_wdata,
  input  logic                smp_valid,
  output logic                smp_ready,
  input  logic [DATA_W-1:0]   smp_data,
  input  logic                peer_in,
  output logic                arm_out,
  output logic                trig_out,
  output logic [STATE_W-1:0]  cur_state
);
  ctrl_t              cl_ctrl [NUM_CLAUSES];
  logic [DATA_W-1:0]  cl_lo   [NUM_CLAUSES];
  logic [DATA_W-1:0]  cl_hi   [NUM_CLAUSES];
  logic [CNT_W-1:0]   term    [NUM_CNT];
  logic [NUM_CLAUSES-1:0] cl_hit;
  logic [NUM_CNT-1:0] cnt_hit;

  logic [STATE_W-1:0] state_q;
  logic trig_q, arm_q, live_q;
  logic take;

  ctrl_t win_ctrl;
  logic  win_vld;

  tsq_cfg_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .state(state_q), .ctrl_o(cl_ctrl), .lo_o(cl_lo), .hi_o(cl_hi), .term_o(term)
  );

  for (genvar c = 0; c < NUM_CLAUSES; c++) begin : g_clause
    tsq_clause_eval #(.DATA_W(DATA_W)) u_eval (
      .ctrl(cl_ctrl[c]), .lo(cl_lo[c]), .hi(cl_hi[c]), .data(smp_data),
      .peer(peer_in), .cnt_hit(cnt_hit), .hit(cl_hit[c])
    );
  end

  // lowest-numbered matching clause wins
  always_comb begin
    win_vld  = 1'b0;
    win_ctrl = '0;
    for (int c = NUM_CLAUSES - 1; c >= 0; c--) begin
      if (cl_hit[c]) begin
        win_vld  = 1'b1;
        win_ctrl = cl_ctrl[c];
      end
    end
  end

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
    logic act_k;
    assign act_k = take && win_vld && (win_ctrl.act_cnt == CSEL_W'(k));
    tsq_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .clr(rearm || (act_k && win_ctrl.clr)),
      .inc(act_k && win_ctrl.inc),
      .term(term[k]), .at_term(cnt_hit[k])
    );
  end

  assign smp_ready = live_q && !trig_q && !rearm;
  assign take      = smp_valid && smp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q  <= 1'b0;
      state_q <= '0;
      trig_q  <= 1'b0;
      arm_q   <= 1'b0;
    end else begin
      live_q <= 1'b1;
      if (rearm) begin
        state_q <= '0;
        trig_q  <= 1'b0;
        arm_q   <= 1'b0;
      end else if (take && win_vld) begin
        if (win_ctrl.go)   state_q <= win_ctrl.nxt;
        if (win_ctrl.arm)  arm_q   <= 1'b1;
        if (win_ctrl.fire) trig_q  <= 1'b1;
      end
    end
  end

  assign cur_state = state_q;
  assign arm_out   = arm_q;
  assign trig_out  = trig_q;
endmodule

// File: rtl/tsq_chk.sv
module tsq_chk
  import tsq_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               rearm,
  input logic               smp_valid,
  input logic               smp_ready,
  input logic               arm_out,
  input logic               trig_out,
  input logic [STATE_W-1:0] cur_state
);
  // R1
  rearm_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rearm |=> (cur_state == '0) && !trig_out && !arm_out);

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(smp_valid && smp_ready) && !rearm) |=> $stable(cur_state) && $stable(trig_out) && $stable(arm_out));

  // R9
  arm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_out && !rearm) |=> arm_out);

  // R10
  trig_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_out && !rearm) |=> trig_out && $stable(cur_state));

  // R10
  trig_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_out) |-> !smp_ready);
endmodule

bind tsq_trigger_seq tsq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rearm(rearm), .smp_valid(smp_valid),
  .smp_ready(smp_ready), .arm_out(arm_out), .trig_out(trig_out),
  .cur_state(cur_state)
);

// File: tb/tsq_trigger_seq_bench.sv
module tsq_trigger_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rearm = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [15:0] smp_data = '0;
  logic        peer_in = 1'b0;
  logic        arm_out, trig_out;
  logic [1:0]  cur_state;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tsq_trigger_seq u_tsq_trigger_seq (
    .clk(clk), .rst_n(rst_n), .rearm(rearm), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .smp_data(smp_data), .peer_in(peer_in),
    .arm_out(arm_out), .trig_out(trig_out), .cur_state(cur_state)
  );

  localparam logic [2:0] K_NEVER = 3'd0, K_MASK = 3'd1, K_RANGE = 3'd2,
                         K_PEER = 3'd3, K_CNT = 3'd4, K_ALL = 3'd5;

  function automatic logic [31:0] mk_ctrl(logic [2:0] kind, logic csel, logic go,
      logic [1:0] nxt, logic inc, logic clr, logic asel, logic arm, logic fire);
    return {20'd0, fire, arm, asel, clr, inc, nxt, go, csel, kind};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic clause(input int st, input int cl, input logic [31:0] ctrl,
      input logic [15:0] a, input logic [15:0] b);
    wr(5'({st[1:0], cl[0], 1'b0}), ctrl);
    wr(5'({st[1:0], cl[0], 1'b1}), {b, a});
  endtask

  task automatic wipe();
    for (int i = 0; i < 16; i++) wr(5'(i), 32'd0);
    wr(5'd16, 32'd0);
    wr(5'd17, 32'd0);
  endtask

  task automatic do_rearm();
    @(negedge clk);
    rearm = 1'b1;
    @(negedge clk);
    rearm = 1'b0;
  endtask

  task automatic send(input logic [15:0] d, input logic p);
    @(negedge clk);
    smp_valid = 1'b1; smp_data = d; peer_in = p;
    @(negedge clk);
    smp_valid = 1'b0; peer_in = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 state", 32'(cur_state), 0);
    check("R1 trig", 32'(trig_out), 0);
    check("R1 arm", 32'(arm_out), 0);
    check("R1 ready", 32'(smp_ready), 1);
  endtask

  task automatic t_mask_range();
    wipe();
    clause(0, 0, mk_ctrl(K_MASK, 0, 1, 2'd1, 0, 0, 0, 0, 0), 16'h1200, 16'hFF00);
    clause(1, 0, mk_ctrl(K_RANGE, 0, 1, 2'd2, 0, 0, 0, 0, 0), 16'h0100, 16'h01FF);
    clause(2, 0, mk_ctrl(K_RANGE, 0, 0, 2'd0, 0, 0, 0, 0, 1), 16'h0100, 16'h01FF);
    check("R12 config write leaves state", 32'(cur_state), 0);
    @(negedge clk);
    smp_data = 16'h12AB;
    repeat (3) @(negedge clk);
    check("R7 no valid no move", 32'(cur_state), 0);
    send(16'h1300, 0);
    check("R2 masked mismatch", 32'(cur_state), 0);
    send(16'h12AB, 0);
    check("R2 R8 masked match goto", 32'(cur_state), 1);
    send(16'h00FF, 0);
    check("R3 below low", 32'(cur_state), 1);
    send(16'h0200, 0);
    check("R3 above high", 32'(cur_state), 1);
    send(16'h01FF, 0);
    check("R3 high inclusive", 32'(cur_state), 2);
    check("R10 no fire yet", 32'(trig_out), 0);
    send(16'h0100, 0);
    check("R3 R10 low inclusive fires", 32'(trig_out), 1);
    check("R10 ready drops", 32'(smp_ready), 0);
    clause(2, 0, mk_ctrl(K_ALL, 0, 1, 2'd3, 0, 0, 0, 0, 0), 16'h0, 16'h0);
    send(16'h0150, 0);
    check("R10 frozen state", 32'(cur_state), 2);
    check("R10 trig held", 32'(trig_out), 1);
    do_rearm();
    check("R1 rearm state", 32'(cur_state), 0);
    check("R1 rearm trig", 32'(trig_out), 0);
    send(16'h12CD, 0);
    check("R1 config kept", 32'(cur_state), 1);
    do_rearm();
  endtask

  task automatic t_peer();
    wipe();
    clause(0, 0, mk_ctrl(K_PEER, 0, 1, 2'd3, 0, 0, 0, 1, 0), 16'h0, 16'h0);
    send(16'h0, 0);
    check("R4 peer low", 32'(arm_out), 0);
    send(16'h0, 1);
    check("R4 R9 peer arms", 32'(arm_out), 1);
    check("R4 peer goto", 32'(cur_state), 3);
    send(16'h0, 0);
    check("R9 arm sticky", 32'(arm_out), 1);
    do_rearm();
    check("R1 arm cleared", 32'(arm_out), 0);
  endtask

  task automatic t_prio();
    wipe();
    clause(0, 0, mk_ctrl(K_MASK, 0, 1, 2'd1, 0, 0, 0, 0, 0), 16'h00AA, 16'hFFFF);
    clause(0, 1, mk_ctrl(K_ALL, 0, 1, 2'd2, 0, 0, 0, 0, 0), 16'h0, 16'h0);
    send(16'h00AA, 0);
    check("R6 clause 0 wins", 32'(cur_state), 1);
    do_rearm();
    send(16'h0001, 0);
    check("R6 clause 1 alone", 32'(cur_state), 2);
    do_rearm();
    wipe();
    send(16'h0000, 1);
    check("R4 never kind", 32'(cur_state), 0);
  endtask

  task automatic t_count();
    wipe();
    wr(5'd17, 32'd3);
    clause(0, 0, mk_ctrl(K_CNT, 1, 0, 2'd0, 0, 0, 0, 0, 1), 16'h0, 16'h0);
    clause(0, 1, mk_ctrl(K_ALL, 0, 0, 2'd0, 1, 0, 1, 0, 0), 16'h0, 16'h0);
    for (int i = 0; i < 3; i++) send(16'(i), 0);
    check("R5 R11 before terminal", 32'(trig_out), 0);
    send(16'h9, 0);
    check("R5 R11 terminal fires", 32'(trig_out), 1);
    do_rearm();
    send(16'h1, 0);
    send(16'h2, 0);
    do_rearm();
    send(16'h3, 0);
    send(16'h4, 0);
    check("R1 counter cleared by rearm", 32'(trig_out), 0);
    do_rearm();
    wipe();
    wr(5'd16, 32'd1);
    clause(0, 0, mk_ctrl(K_CNT, 0, 0, 2'd0, 0, 0, 0, 0, 1), 16'h0, 16'h0);
    clause(0, 1, mk_ctrl(K_ALL, 0, 0, 2'd0, 1, 1, 0, 0, 0), 16'h0, 16'h0);
    for (int i = 0; i < 5; i++) send(16'(i), 0);
    check("R11 clear beats increment", 32'(trig_out), 0);
    do_rearm();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask_range();
    t_peer();
    t_prio();
    t_count();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule